// File: doc/BRIEF.md
# SDRAM Command Sequencer with Concurrent Auto Precharge

The block turns single memory requests into the command stream for a multi-bank SDRAM. A request names a bank, row and column, gives the direction, and says whether the bank is to close itself after the access. The sequencer holds a state and a countdown for every bank. It opens rows with ACTIVE, closes a mismatched row with PRECHARGE, and issues READ or WRITE once the row-to-column delay has passed. It also asserts DQM ahead of a write that would otherwise meet read data still on the data bus. It tells the data path when read data is due with a capture strobe.

A read with auto precharge does not block the other banks. A column command to any other bank cuts that read short, and the closing bank starts its precharge countdown in the cycle the cutting command is issued. The write burst mode input selects single-column writes. In that mode a write with auto precharge closes its bank earlier than a full burst would. All timing values are parameters.

Top module: `sdram_ap_sequencer`

## Requirements
- R1: Commands are coded on {cs_n, ras_n, cas_n, we_n} as NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100 and PRECHARGE 0010. In reset, and when no request is pending, the outputs are NOP with DQM low, ready low, bank and address zero, and no capture strobe.
- R2: An ACTIVE to a closed bank carries the row on the address bus. The READ or WRITE to that bank comes no sooner than T_RCD cycles later. It carries the column in the low address bits and the auto-precharge flag on address bit 10.
- R3: A request to an open bank with a different row causes a PRECHARGE to that bank (address zero). The next ACTIVE to that bank comes exactly T_RP cycles after the PRECHARGE.
- R4: After a READ with auto precharge that nothing cuts short, the bank accepts a new ACTIVE BURST_LEN + T_RP cycles after the READ.
- R5: A READ or WRITE to another bank, issued while a read with auto precharge is still in its burst, starts that bank's precharge at once. Its next ACTIVE follows T_RP cycles after the cutting command.
- R6: With the write burst mode input low, a WRITE with auto precharge reopens its bank BURST_LEN - 1 + T_DPL + T_RP cycles after the WRITE. Commands to other banks do not shorten this.
- R7: With the write burst mode input high, a WRITE covers one column, and a WRITE with auto precharge reopens its bank T_DPL + T_RP cycles after the WRITE.
- R8: A WRITE that would overlap pending read data is preceded by exactly three NOP cycles with DQM high. DQM is low during the WRITE itself. A WRITE with no read data pending goes out at once.
- R9: The capture strobe is high from CAS_LAT cycles after a READ for BURST_LEN cycles. A later READ takes over the strobe at its own CAS_LAT point.
- R10: A WRITE ends all pending read capture from the next cycle on.
- R11: The ready output is high exactly in the cycles where a READ or WRITE for the offered request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_single | input | 1 | Write burst mode: 1 gives single-column writes |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 for write, 0 for read |
| req_autopre | input | 1 | Close the bank after this access |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 9 | Target column |
| req_ready | output | 1 | Request accepted this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row, or column with bit 10 as auto-precharge flag |
| sd_dqm | output | 1 | Data mask |
| rd_capture | output | 1 | Read data is on the bus this cycle |

## Verification
In one cycle the sequencer can both end one bank's auto-precharge read and start the next read's data on the bus. The bench provokes this by sending a read to an open bank in the cycle right after a closing read on another bank, while the first burst is still coming back. A behavioural model with per-bank reopen times and a per-cycle capture map predicts two things: the reopen cycle of the cut bank and a capture strobe that runs without a gap. Both are compared with the ports on every clock. A write that must cut pending read data is handled the same way: the model predicts the DQM lead and the end of capture, and the bench compares both against the outputs.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE,
        BK_OPEN,
        BK_APRD,
        BK_APWR,
        BK_PRE
    } bank_st_e;

    localparam int DQM_LEAD = 3;
    localparam int AP_BIT   = 10;

    function automatic logic is_column(cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/sdseq_bank.sv
module sdseq_bank
    import sdseq_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int CNT_W     = 6,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_DPL     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_e             cmd,
    input  logic             sel,
    input  logic             ap,
    input  logic             wr_single,
    input  logic [ROW_W-1:0] row,
    output logic             can_act,
    output logic             can_col,
    output logic             row_hit
);
    localparam logic [CNT_W-1:0] LD_RCD  = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] LD_RP   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_RDAP = CNT_W'(BURST_LEN - 1);
    localparam logic [CNT_W-1:0] LD_WRBL = CNT_W'(BURST_LEN - 1 + T_DPL - 1);
    localparam logic [CNT_W-1:0] LD_WR1  = CNT_W'(T_DPL - 1);

    bank_st_e         state;
    logic [CNT_W-1:0] cnt;
    logic [ROW_W-1:0] open_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= BK_IDLE;
            cnt      <= '0;
            open_row <= '0;
        end else if (sel && cmd == CMD_ACT) begin
            state    <= BK_OPEN;
            cnt      <= LD_RCD;
            open_row <= row;
        end else if (sel && cmd == CMD_PRE) begin
            state <= BK_PRE;
            cnt   <= LD_RP;
        end else if (sel && is_column(cmd) && ap) begin
            if (cmd == CMD_RD) begin
                state <= BK_APRD;
                cnt   <= LD_RDAP;
            end else begin
                state <= BK_APWR;
                cnt   <= wr_single ? LD_WR1 : LD_WRBL;
            end
        end else if (!sel && is_column(cmd) && state == BK_APRD) begin
            // another bank's access cuts the closing read short
            state <= BK_PRE;
            cnt   <= LD_RP;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else begin
            case (state)
                BK_APRD, BK_APWR: begin
                    state <= BK_PRE;
                    cnt   <= LD_RP;
                end
                BK_PRE:  state <= BK_IDLE;
                default: state <= state;
            endcase
        end
    end

    assign can_act = (state == BK_IDLE || state == BK_PRE) && (cnt == '0);
    assign can_col = (state == BK_OPEN) && (cnt == '0);
    assign row_hit = (open_row == row);

endmodule

// File: rtl/sdseq_dqtrack.sv
module sdseq_dqtrack
    import sdseq_pkg::*;
#(
    parameter int CAS_LAT   = 3,
    parameter int BURST_LEN = 4,
    parameter int CNT_W     = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_go,
    input  logic wr_go,
    input  logic mask_go,
    output logic rd_busy,
    output logic lead_zero,
    output logic lead_full,
    output logic rd_capture
);
    localparam logic [CNT_W-1:0] LD_BUSY = CNT_W'(CAS_LAT + BURST_LEN - 1);
    localparam logic [CNT_W-1:0] LD_BEAT = CNT_W'(BURST_LEN - 1);

    logic [CNT_W-1:0]   busy_cnt;
    logic [CNT_W-1:0]   beat_cnt;
    logic [2:0]         lead_cnt;
    logic [CAS_LAT-1:0] lat_sh;

    always_ff @(posedge clk) begin
        if (rst || wr_go) begin
            busy_cnt <= '0;
            beat_cnt <= '0;
            lead_cnt <= '0;
            lat_sh   <= '0;
        end else begin
            lat_sh <= (lat_sh << 1) | CAS_LAT'(rd_go);
            if (rd_go)
                busy_cnt <= LD_BUSY;
            else if (busy_cnt != '0)
                busy_cnt <= busy_cnt - 1'b1;
            if (lat_sh[CAS_LAT-1])
                beat_cnt <= LD_BEAT;
            else if (beat_cnt != '0)
                beat_cnt <= beat_cnt - 1'b1;
            if (mask_go)
                lead_cnt <= lead_cnt + 1'b1;
        end
    end

    assign rd_busy    = (busy_cnt != '0);
    assign lead_zero  = (lead_cnt == '0);
    assign lead_full  = (lead_cnt == 3'(DQM_LEAD));
    assign rd_capture = lat_sh[CAS_LAT-1] || (beat_cnt != '0);

endmodule

// File: rtl/sdram_ap_sequencer.sv
module sdram_ap_sequencer
    import sdseq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9,
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 3,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_DPL     = 2,
    parameter int CNT_W     = 6,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wb_single,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_autopre,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             req_ready,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [BA_W-1:0]  sd_ba,
    output logic [ROW_W-1:0] sd_addr,
    output logic             sd_dqm,
    output logic             rd_capture
);
    cmd_e             cmd;
    logic             can_act [NUM_BANKS];
    logic             can_col [NUM_BANKS];
    logic             row_hit [NUM_BANKS];
    logic             rd_busy, lead_zero, lead_full, mask_go;
    logic [ROW_W-1:0] col_word;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        sdseq_bank #(
            .ROW_W(ROW_W), .CNT_W(CNT_W), .BURST_LEN(BURST_LEN),
            .T_RCD(T_RCD), .T_RP(T_RP), .T_DPL(T_DPL)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .cmd      (cmd),
            .sel      (req_bank == BA_W'(i)),
            .ap       (req_autopre),
            .wr_single(wb_single),
            .row      (req_row),
            .can_act  (can_act[i]),
            .can_col  (can_col[i]),
            .row_hit  (row_hit[i])
        );
    end

    sdseq_dqtrack #(
        .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .CNT_W(CNT_W)
    ) u_dq (
        .clk       (clk),
        .rst       (rst),
        .rd_go     (cmd == CMD_RD),
        .wr_go     (cmd == CMD_WR),
        .mask_go   (mask_go),
        .rd_busy   (rd_busy),
        .lead_zero (lead_zero),
        .lead_full (lead_full),
        .rd_capture(rd_capture)
    );

    always_comb begin
        cmd       = CMD_NOP;
        sd_ba     = '0;
        sd_addr   = '0;
        mask_go   = 1'b0;
        req_ready = 1'b0;
        col_word  = ROW_W'(req_col);
        col_word[AP_BIT] = req_autopre;
        if (req_valid) begin
            if (can_col[req_bank]) begin
                if (!row_hit[req_bank]) begin
                    cmd   = CMD_PRE;
                    sd_ba = req_bank;
                end else if (!req_write || lead_full || (lead_zero && !rd_busy)) begin
                    cmd       = req_write ? CMD_WR : CMD_RD;
                    sd_ba     = req_bank;
                    sd_addr   = col_word;
                    req_ready = 1'b1;
                end else begin
                    mask_go = 1'b1;
                end
            end else if (can_act[req_bank]) begin
                cmd     = CMD_ACT;
                sd_ba   = req_bank;
                sd_addr = req_row;
            end
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_dqm = mask_go;

endmodule

// File: rtl/sdseq_chk.sv
module sdseq_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic dqm,
    input logic ready,
    input logic capture
);
    logic [3:0] pins;
    assign pins = {cs_n, ras_n, cas_n, we_n};

    // R1: only the five legal codes appear
    p_cmd_legal_r1: assert property (@(posedge clk) disable iff (rst)
        pins == 4'b0111 || pins == 4'b0011 || pins == 4'b0101 ||
        pins == 4'b0100 || pins == 4'b0010);

    // R8: masking cycles carry no command
    p_dqm_nop_r8: assert property (@(posedge clk) disable iff (rst)
        dqm |-> pins == 4'b0111);

    // R8: a masked lead before a write lasts three cycles
    p_dqm_lead_r8: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0100 && $past(dqm)) |-> ($past(dqm, 2) && $past(dqm, 3) && !dqm));

    // R11: acceptance coincides with a column command
    p_ready_col_r11: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!cs_n && ras_n && !cas_n));

    // R10: a write ends read capture
    p_cap_kill_r10: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0100) |=> !capture);

endmodule

bind sdram_ap_sequencer sdseq_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (sd_cs_n),
    .ras_n  (sd_ras_n),
    .cas_n  (sd_cas_n),
    .we_n   (sd_we_n),
    .dqm    (sd_dqm),
    .ready  (req_ready),
    .capture(rd_capture)
);

// File: tb/sdram_ap_sequencer_tb.sv
module sdram_ap_sequencer_tb;
    localparam int BL = 4, CL = 3, TRCD = 2, TRP = 2, TDPL = 2;
    localparam int NOP = 7, ACT = 3, RD = 5, WR = 4, PRE = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic wb_single = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, rd_capture;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;

    always #10 clk = ~clk;

    sdram_ap_sequencer u_dut (
        .clk(clk), .rst(rst), .wb_single(wb_single), .req_valid(req_valid),
        .req_write(req_write), .req_autopre(req_autopre), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .req_ready(req_ready),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .rd_capture(rd_capture)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit    m_open [4];
    int    m_row [4], m_colok [4], m_actok [4], m_apend [4];
    string m_tag [4];
    int    rd_last = -1, lead = 0;
    bit    cap [0:8191];
    int    obs_act [4], obs_pre [4], obs_col [4];
    int    obs_lead = 0, dqm_run = 0, obs_caprise = 0;
    bit    cap_prev = 0;
    int    e_cmd, e_ba, e_addr, e_dqm, e_rdy, e_cap, b, dcmd, wl;
    string e_tag;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_open[i] = 0; m_row[i] = 0; m_colok[i] = 0; m_actok[i] = 0;
            m_apend[i] = -1; m_tag[i] = "R1";
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            e_cmd = NOP; e_ba = 0; e_addr = 0; e_dqm = 0; e_rdy = 0; e_tag = "R1";
            b = int'(req_bank);
            if (req_valid) begin
                if (m_open[b]) begin
                    if (cyc < m_colok[b]) e_tag = "R2";
                    else if (m_row[b] != int'(req_row)) begin
                        e_cmd = PRE; e_ba = b; e_tag = "R3";
                    end else if (!req_write || lead == 3 || (lead == 0 && rd_last < cyc)) begin
                        e_cmd = req_write ? WR : RD; e_ba = b; e_rdy = 1;
                        e_addr = int'(req_col) + (req_autopre ? 1024 : 0);
                        e_tag = req_write ? "R8" : (req_autopre ? "R4" : "R2");
                    end else begin
                        e_dqm = 1; e_tag = "R8";
                    end
                end else if (cyc >= m_actok[b]) begin
                    e_cmd = ACT; e_ba = b; e_addr = int'(req_row); e_tag = "R2";
                end else e_tag = m_tag[b];
            end
            e_cap = (cyc < 8192) ? int'(cap[cyc]) : 0;
            dcmd = int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n});
            chk(e_tag, dcmd, e_cmd);
            chk(e_tag, int'(sd_ba), e_ba);
            chk(e_tag, int'(sd_addr), e_addr);
            chk("R8", int'(sd_dqm), e_dqm);
            chk("R11", int'(req_ready), e_rdy);
            chk("R9", int'(rd_capture), e_cap);
            // observed command history
            if (dcmd == ACT) obs_act[sd_ba] = cyc;
            if (dcmd == PRE) obs_pre[sd_ba] = cyc;
            if (dcmd == RD || dcmd == WR) obs_col[sd_ba] = cyc;
            if (dcmd == WR) obs_lead = dqm_run;
            dqm_run = sd_dqm ? dqm_run + 1 : 0;
            if (rd_capture && !cap_prev) obs_caprise = cyc;
            cap_prev = rd_capture;
            // model update
            if (e_cmd == RD || e_cmd == WR) begin
                for (int k = 0; k < 4; k++)
                    if (k != b && !m_open[k] && m_apend[k] > cyc) begin
                        m_actok[k] = cyc + TRP; m_apend[k] = -1; m_tag[k] = "R5";
                    end
            end
            if (e_cmd == RD) begin
                for (int k = 0; k < BL; k++) if (cyc + CL + k < 8192) cap[cyc + CL + k] = 1;
                rd_last = cyc + CL + BL - 1;
                if (req_autopre) begin
                    m_open[b] = 0; m_actok[b] = cyc + BL + TRP; m_apend[b] = cyc + BL; m_tag[b] = "R4";
                end
            end else if (e_cmd == WR) begin
                for (int k = 1; k <= CL + BL; k++) if (cyc + k < 8192) cap[cyc + k] = 0;
                rd_last = -1; lead = 0;
                wl = wb_single ? 1 : BL;
                if (req_autopre) begin
                    m_open[b] = 0; m_actok[b] = cyc + wl - 1 + TDPL + TRP; m_apend[b] = -1;
                    m_tag[b] = wb_single ? "R7" : "R6";
                end
            end else if (e_cmd == ACT) begin
                m_open[b] = 1; m_row[b] = int'(req_row); m_colok[b] = cyc + TRCD; m_apend[b] = -1;
            end else if (e_cmd == PRE) begin
                m_open[b] = 0; m_actok[b] = cyc + TRP; m_apend[b] = -1; m_tag[b] = "R3";
            end
            if (e_dqm == 1) lead++;
            cyc++;
        end
    end

    task automatic do_req(bit wr, int bank, int row, int col, bit ap);
        req_write = wr; req_bank = 2'(bank); req_row = 13'(row);
        req_col = 9'(col); req_autopre = ap; req_valid = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    int t_w;

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), NOP);
        chk("R1", int'(sd_dqm), 0);
        chk("R1", int'(req_ready), 0);
        chk("R1", int'(rd_capture), 0);
        @(posedge clk); #1 rst = 1'b0;
        idle(3);
        // R2 open and read
        do_req(0, 0, 5, 8, 0);
        chk("R2", obs_col[0] - obs_act[0], TRCD);
        idle(12);
        chk("R9", obs_caprise - obs_col[0], CL);
        do_req(0, 0, 5, 16, 0);
        // R3 row change
        do_req(0, 0, 7, 0, 0);
        chk("R3", obs_act[0] - obs_pre[0], TRP);
        do_req(0, 1, 3, 4, 0);
        idle(12);
        // R8 / R10 write cutting pending read data
        do_req(0, 0, 7, 1, 0);
        do_req(1, 1, 3, 5, 0);
        chk("R8", obs_lead, 3);
        @(negedge clk);
        chk("R10", int'(rd_capture), 0);
        idle(12);
        do_req(1, 1, 3, 6, 0);
        chk("R8", obs_lead, 0);
        // R5 interrupt of a closing read
        do_req(0, 3, 2, 0, 0);
        idle(12);
        do_req(0, 2, 1, 4, 1);
        do_req(0, 3, 2, 8, 0);
        do_req(0, 2, 1, 0, 0);
        chk("R5", obs_act[2] - obs_col[3], TRP);
        idle(12);
        // R4 closing read left alone
        do_req(0, 2, 1, 2, 1);
        t_w = obs_col[2];
        do_req(0, 2, 1, 3, 0);
        chk("R4", obs_act[2] - t_w, BL + TRP);
        idle(12);
        // R6 full-burst write with auto precharge
        do_req(1, 1, 3, 7, 1);
        t_w = obs_col[1];
        do_req(0, 3, 2, 1, 0);
        do_req(0, 1, 3, 0, 0);
        chk("R6", obs_act[1] - t_w, BL - 1 + TDPL + TRP);
        idle(12);
        // R7 single-column writes
        wb_single = 1'b1;
        do_req(1, 1, 3, 9, 1);
        t_w = obs_col[1];
        do_req(0, 1, 3, 2, 0);
        chk("R7", obs_act[1] - t_w, TDPL + TRP);
        wb_single = 1'b0;
        idle(12);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule